// File: doc/BRIEF.md
# Memory Relocation and Protection Unit

This unit sits in the path from a processor to its memory and turns every 18-bit program address into an 18-bit physical address. The processor runs in one of two privilege modes. In executive mode an address passes straight through, with no offset and no bound check. In user mode each access is first compared with a segment size and, if it lies inside the segment, is moved up by a base. Both the size and the base are counted in 1024-word blocks.

The executive loads the base and the size through a small load port before it hands control to a user program. An access that falls outside the user segment is held back from memory in the same cycle. It also sets a sticky violation flag that stays up until the executive clears it. The address space is 262,144 words on both sides of the unit.

Top module: `memRelocUnit`

## Requirements
- R1: After reset the base and the size are both 0 and the violation flag is low. With the size at 0, every user-mode access is refused.
- R2: In executive mode a valid access is always granted. physAddr equals reqAddr unchanged, whatever the base and size hold.
- R3: In user mode, an access whose block index (reqAddr bits 17:10) is below the size is granted. physAddr is then (base × 1024 + reqAddr) modulo 2^18, so an address near the top of the space wraps to the bottom.
- R4: In user mode, an access whose block index is at or above the size is refused: grant is low and violation is high in that same cycle. A size of 0 refuses every user access, and a size of 255 refuses only block 255.
- R5: Once a violation has occurred, the violation flag stays high until clrViol is asserted while execMode is high; it is low from the next cycle on. clrViol asserted in user mode has no effect.
- R6: With ldEn high and execMode high, ldData[7:0] is written at the clock edge, into the base when ldSel is 1 and into the size when ldSel is 0. A load attempted in user mode changes neither register.
- R7: When grant is low, physAddr is 0 and physWrite is low. When grant is high, physWrite equals reqWrite. With reqValid low, grant is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| execMode | input | 1 | 1 = executive mode, 0 = user mode |
| ldEn | input | 1 | Register load strobe |
| ldSel | input | 1 | Load target: 1 = base, 0 = size |
| ldData | input | 8 | Block count to load |
| clrViol | input | 1 | Clear the sticky violation flag (executive mode only) |
| reqValid | input | 1 | Access request present |
| reqAddr | input | 18 | Program address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| physAddr | output | 18 | Physical address (0 when not granted) |
| grant | output | 1 | Access may proceed to memory |
| physWrite | output | 1 | Write direction of the granted access |
| violation | output | 1 | Protection violation, current or sticky |

## Verification
A corrupted size register shows up as a wrong grant/violation boundary. The first user access in the affected block range shows it, combinationally, in that cycle. A corrupted base shows at once as a physAddr shifted by a whole number of blocks, while the low ten bits stay correct. A stuck or lost sticky bit shows one cycle after a faulting access, or one cycle after a clear. The bench therefore sweeps every block index against several sizes and bases and checks all four outputs on each access.

// File: rtl/relocPkg.sv
package relocPkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadBase;  // write ldData into the base register
    logic loadSize;  // write ldData into the size register
    logic passThru;  // executive mode: bypass relocation
    logic drive;     // access granted: drive the physical address
  } pathCmd_t;
endpackage

// File: rtl/relocPath.sv
module relocPath
  import relocPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int OFF_W  = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pathCmd_t                 cmd,
  input  logic [ADDR_W-OFF_W-1:0]  ldData,
  input  logic [ADDR_W-1:0]        reqAddr,
  output logic                     inRange,
  output logic [ADDR_W-1:0]        physAddr
);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [BLK_W-1:0]  baseReg;
  logic [BLK_W-1:0]  sizeReg;
  logic [BLK_W-1:0]  blkIdx;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] relocAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      sizeReg <= '0;
    end else begin
      if (cmd.loadBase) baseReg <= ldData;
      if (cmd.loadSize) sizeReg <= ldData;
    end
  end

  always_comb begin
    blkIdx    = reqAddr[ADDR_W-1:OFF_W];
    inRange   = (blkIdx < sizeReg);
    baseAddr  = {baseReg, {OFF_W{1'b0}}};
    relocAddr = reqAddr + baseAddr;  // truncation gives the wrap
    if (!cmd.drive)       physAddr = '0;
    else if (cmd.passThru) physAddr = reqAddr;
    else                   physAddr = relocAddr;
  end
endmodule

// File: rtl/relocCtrl.sv
module relocCtrl
  import relocPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     execMode,
  input  logic     ldEn,
  input  logic     ldSel,
  input  logic     clrViol,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     inRange,
  output pathCmd_t cmd,
  output logic     grant,
  output logic     physWrite,
  output logic     violation
);
  logic violReg;
  logic userFault;

  always_comb begin
    userFault     = reqValid & ~execMode & ~inRange;
    grant         = reqValid & (execMode | inRange);
    physWrite     = grant & reqWrite;
    violation     = violReg | userFault;
    cmd.loadBase  = execMode & ldEn & ldSel;
    cmd.loadSize  = execMode & ldEn & ~ldSel;
    cmd.passThru  = execMode;
    cmd.drive     = grant;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    violReg <= 1'b0;
    else if (execMode && clrViol) violReg <= 1'b0;
    else if (userFault)           violReg <= 1'b1;
  end
endmodule

// File: rtl/memRelocUnit.sv
module memRelocUnit
  import relocPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int OFF_W  = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    execMode,
  input  logic                    ldEn,
  input  logic                    ldSel,
  input  logic [ADDR_W-OFF_W-1:0] ldData,
  input  logic                    clrViol,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqWrite,
  output logic [ADDR_W-1:0]       physAddr,
  output logic                    grant,
  output logic                    physWrite,
  output logic                    violation
);
  pathCmd_t cmd;
  logic     inRange;

  relocCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .execMode(execMode), .ldEn(ldEn), .ldSel(ldSel),
    .clrViol(clrViol), .reqValid(reqValid), .reqWrite(reqWrite),
    .inRange(inRange), .cmd(cmd), .grant(grant), .physWrite(physWrite),
    .violation(violation)
  );

  relocPath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ldData(ldData),
    .reqAddr(reqAddr), .inRange(inRange), .physAddr(physAddr)
  );
endmodule

// File: rtl/memRelocUnitChk.sv
module memRelocUnitChk #(
  parameter int ADDR_W = 18,
  parameter int OFF_W  = 10
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    execMode,
  input logic                    clrViol,
  input logic                    reqValid,
  input logic [ADDR_W-1:0]       reqAddr,
  input logic                    reqWrite,
  input logic [ADDR_W-1:0]       physAddr,
  input logic                    grant,
  input logic                    physWrite,
  input logic                    violation
);
  a_r2_exec_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (execMode && reqValid) |-> (grant && physAddr == reqAddr));

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!execMode && grant) |-> (physAddr[OFF_W-1:0] == reqAddr[OFF_W-1:0]));

  a_r4_refusal_flags: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !grant) |-> violation);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (violation && !(execMode && clrViol)) |=> violation);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (execMode && clrViol) |=> (!violation || (reqValid && !execMode && !grant)));

  a_r7_quiet_when_refused: assert property (@(posedge clk) disable iff (!rstN)
    !grant |-> (physAddr == '0 && !physWrite));

  a_r7_write_follows: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> (physWrite == reqWrite));
endmodule

bind memRelocUnit memRelocUnitChk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (
  .clk(clk), .rstN(rstN), .execMode(execMode), .clrViol(clrViol),
  .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
  .physAddr(physAddr), .grant(grant), .physWrite(physWrite),
  .violation(violation)
);

// File: tb/test_memRelocUnit.sv
module test_memRelocUnit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        execMode, ldEn, ldSel, clrViol, reqValid, reqWrite;
  logic [7:0]  ldData;
  logic [17:0] reqAddr;
  logic [17:0] physAddr;
  logic        grant, physWrite, violation;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int mBase = 0, mSize = 0;
  bit mViol = 0;

  always #5 clk = ~clk;

  memRelocUnit i_memRelocUnit (
    .clk(clk), .rstN(rstN), .execMode(execMode), .ldEn(ldEn), .ldSel(ldSel),
    .ldData(ldData), .clrViol(clrViol), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .physAddr(physAddr), .grant(grant),
    .physWrite(physWrite), .violation(violation)
  );

  task automatic check(string tag, logic [17:0] eP, bit eG, bit eW, bit eV);
    compared++;
    if (physAddr !== eP || grant !== eG || physWrite !== eW || violation !== eV) begin
      mismatched++;
      $display("FAIL %s: got phys=%h grant=%b wr=%b viol=%b, expected phys=%h grant=%b wr=%b viol=%b",
               tag, physAddr, grant, physWrite, violation, eP, eG, eW, eV);
    end
  endtask

  // One cycle: drive, check outputs against the model, then advance the model.
  task automatic step(string tag, bit ex, bit le, bit ls, int ld, bit clr,
                      bit val, int addr, bit wr);
    bit eG, eV, fault;
    int eP, blk;
    @(negedge clk);
    execMode = ex; ldEn = le; ldSel = ls; ldData = ld[7:0]; clrViol = clr;
    reqValid = val; reqAddr = addr[17:0]; reqWrite = wr;
    #1;
    blk   = (addr >> 10) & 255;
    fault = val && !ex && (blk >= mSize);
    eG    = val && (ex || blk < mSize);
    eP    = !eG ? 0 : (ex ? addr : (((mBase << 10) + addr) & 18'h3FFFF));
    eV    = mViol || fault;
    check(tag, eP[17:0], eG, eG && wr, eV);
    @(posedge clk);
    if (ex && clr) mViol = 0;
    else if (fault) mViol = 1;
    if (ex && le) begin
      if (ls) mBase = ld & 255;
      else    mSize = ld & 255;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int sizes[5] = '{0, 1, 5, 128, 255};
    int bases[4] = '{0, 3, 200, 255};
    rstN = 0; execMode = 0; ldEn = 0; ldSel = 0; ldData = 0; clrViol = 0;
    reqValid = 0; reqAddr = 0; reqWrite = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 in reset", 18'h0, 0, 0, 0);
    rstN = 1;

    // R1: size 0 out of reset refuses a user access, which sets the flag.
    step("R1", 0, 0, 0, 0, 0, 1, 18'h00010, 0);
    step("R5 sticky", 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: clear from user mode is ignored.
    step("R5 user clear", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R5 still set", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5 exec clear", 1, 0, 0, 0, 1, 0, 0, 0);
    step("R5 cleared", 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: no request -> no grant.
    step("R7 idle", 1, 0, 0, 0, 0, 0, 18'h3ABCD, 1);

    // R2: executive sweep over every block, base/size nonzero.
    step("R6 load base", 1, 1, 1, 77, 0, 0, 0, 0);
    step("R6 load size", 1, 1, 0, 9, 0, 0, 0, 0);
    for (int b = 0; b < 256; b++)
      step("R2", 1, 0, 0, 0, 0, 1, (b << 10) | ((b * 37) & 1023), b & 1);

    // R6: loads from user mode are ignored.
    step("R6 user load base", 0, 1, 1, 5, 0, 0, 0, 0);
    step("R6 user load size", 0, 1, 0, 200, 0, 0, 0, 0);
    step("R6 base kept", 0, 0, 0, 0, 0, 1, 18'h00C05, 1);
    step("R6 size kept", 0, 0, 0, 0, 0, 1, (9 << 10), 0);
    step("R5 clear", 1, 0, 0, 0, 1, 0, 0, 0);

    // R3/R4: user sweeps over sizes, bases and every block index.
    foreach (sizes[si]) begin
      foreach (bases[bi]) begin
        step("R6 base", 1, 1, 1, bases[bi], 1, 0, 0, 0);
        step("R6 size", 1, 1, 0, sizes[si], 0, 0, 0, 0);
        for (int b = 0; b < 256; b++) begin
          if (b % 64 == 63)
            step("R5 periodic clear", 1, 0, 0, 0, 1, 0, 0, 0);
          step((b < sizes[si]) ? "R3" : "R4", 0, 0, 0, 0, 0, 1,
               (b << 10) | ((b * 13 + bi) & 1023), (b + bi) & 1);
        end
      end
    end

    // R7: refused write shows neither address nor write strobe.
    step("R5 clear", 1, 0, 0, 0, 1, 0, 0, 0);
    step("R7 refused write", 0, 0, 0, 0, 0, 1, 18'h3FFFF, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule